// File: doc/BRIEF.md
# Serial Register-Programming Slave

This block is a two-wire serial slave that loads a small bank of 8-bit configuration registers from an external controller. It samples the clock line and the data line with the system clock, finds start and stop conditions, and follows a fixed transfer grammar. The block only takes part on the bus while an active-low enable input is held low. Every register drives a slice of one flat parallel output that other logic reads.

A write transfer carries a one-byte device address, a register index and one data byte, and the slave acknowledges each of the three. A read has two parts. First, the controller writes an index and sends a stop. It then sends a new start and the read address. The slave acknowledges, shifts out the indexed register, and the controller ends with a not-acknowledge and a stop. The slave never drives the data line high. It only asserts a pull-low enable, and an external pull-up or the controller sets the level seen on the bus.

Top module: `cfg_serial_slave`

## Requirements
- R1: A start condition is the data line falling while the clock line is high. When the block is enabled, a start always begins a new address byte. This holds even in the middle of a transfer. Data bits are sampled on each rising clock-line edge, most significant bit first.
- R2: The address byte is accepted when its upper seven bits are all zero. Its bit 0 gives the direction: 0 is a write and 1 is a read. On acceptance the slave pulls the data line low from the clock-line fall after the eighth bit until the next clock-line fall. If any upper bit is 1, the slave gives no acknowledge and ignores the bus until the next start or stop.
- R3: After a write address, the next byte is the register index. The slave acknowledges it and keeps it. The byte after that is acknowledged and stored in the register at that index. Any further bytes in the same transfer are not acknowledged and change no register.
- R4: After an acknowledged read address, the slave shifts out the register selected by the most recently received index. It sends the most significant bit first and sets each bit after a clock-line fall. The pull-low enable is asserted exactly for the 0 bits. After the eighth bit the slave releases the line for the controller's acknowledge bit. It then sends nothing more until the next start.
- R5: Every index byte is acknowledged. A data write to an index at or above NUM_REGS is acknowledged and discarded. A read from such an index returns 0x00.
- R6: A stop condition is the data line rising while the clock line is high. A stop returns the slave to idle with the line released. A repeated start during a write abandons the bytes already received, and the transfer restarts with an address byte.
- R7: While the enable input is high, the pull-low enable is 0 after the next system clock edge. The state machine is idle, and bus activity creates no acknowledges and no register writes.
- R8: After reset, every register reads 0 and the pull-low enable is 0.
- R9: Register k appears on cfg_regs_o bits [8k+7:8k]. A stored data byte shows there before the acknowledge clock pulse of that byte rises.
- R10: The slave asserts the pull-low enable only during a low phase of the clock line. This happens one system clock after it sees a clock-line fall, and never while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_ni | input | 1 | Active-low interface enable |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | When 1, the data line is driven low (open-drain enable) |
| cfg_regs_o | output | 8*NUM_REGS | Flat register contents, register k in bits [8k+7:8k] |

## Verification
Each bus line goes through two synchronising flops and one edge-detect compare before the state register. Because of this, the pull-low enable and any register write change on the third rising system-clock edge after the line changes. The enable input acts on the first edge. The bench holds each clock-line half period for eight system clocks and samples the data line one system clock before it raises or drops the clock line. It therefore reads acknowledges and returned bits well after the slave has settled. Register contents are read five clocks after the clock-line fall that ends a data byte, which checks that the store lands before the acknowledge pulse rises. The enable check is read one clock after the input is raised.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } cfgs_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_INDEX,
        K_DATA
    } cfgs_kind_e;

    typedef struct packed {
        cfgs_state_e        state;
        cfgs_kind_e         kind;
        logic [BYTE_W-1:0]  shreg;
        logic [CNT_W-1:0]   cnt;
        logic               full;
        logic               rd_dir;
        logic [BYTE_W-1:0]  index;
        logic               pull;
    } cfgs_ctx_t;

endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] pipe_q [LINES];
    logic [TAPS-1:0] pipe_d [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_comb begin
            pipe_d[g] = {pipe_q[g][TAPS-2:0], raw_i[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                pipe_q[g] <= '1;
            end else begin
                pipe_q[g] <= pipe_d[g];
            end
        end

        assign lvl_o[g]  = pipe_q[g][STAGES-1];
        assign rise_o[g] = pipe_q[g][STAGES-1] & ~pipe_q[g][STAGES];
        assign fall_o[g] = ~pipe_q[g][STAGES-1] & pipe_q[g][STAGES];
    end

endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank #(
    parameter int NUM_REGS = 20,
    parameter int REG_W    = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [REG_W-1:0]          wr_idx_i,
    input  logic [REG_W-1:0]          wr_data_i,
    input  logic [REG_W-1:0]          rd_idx_i,
    output logic [REG_W-1:0]          rd_data_o,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    logic [REG_W-1:0] regs_q [NUM_REGS];
    logic [REG_W-1:0] regs_d [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_comb begin
            regs_d[k] = regs_q[k];
            if (wr_en_i && (wr_idx_i == REG_W'(k))) begin
                regs_d[k] = wr_data_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                regs_q[k] <= '0;
            end else begin
                regs_q[k] <= regs_d[k];
            end
        end

        assign regs_o[k*REG_W +: REG_W] = regs_q[k];
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx_i == REG_W'(k)) begin
                rd_data_o = regs_q[k];
            end
        end
    end

    // R5
    oob_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (int'(wr_idx_i) >= NUM_REGS)) |=> $stable(regs_o));

    // R8
    reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (regs_o == '0));

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgs_pkg::*;
#(
    parameter int NUM_REGS    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       bus_en_ni,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs_o
);

    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [1:0] lvl, rise, fall;

    cfgs_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_lvl  = lvl[LN_SCL];
    assign sda_lvl  = lvl[LN_SDA];
    assign scl_rise = rise[LN_SCL];
    assign scl_fall = fall[LN_SCL];
    assign start_ev = scl_lvl & fall[LN_SDA];
    assign stop_ev  = scl_lvl & rise[LN_SDA];

    cfgs_ctx_t ctx_d, ctx_q;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;

    cfgs_regbank #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (BYTE_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_idx_i  (ctx_q.index),
        .wr_data_i (ctx_q.shreg),
        .rd_idx_i  (ctx_q.index),
        .rd_data_o (rd_data),
        .regs_o    (cfg_regs_o)
    );

    always_comb begin
        ctx_d = ctx_q;
        wr_en = 1'b0;
        if (bus_en_ni) begin
            ctx_d.state = ST_IDLE;
            ctx_d.pull  = 1'b0;
            ctx_d.full  = 1'b0;
            ctx_d.cnt   = '0;
        end else if (start_ev) begin
            ctx_d.state = ST_RX;
            ctx_d.kind  = K_ADDR;
            ctx_d.cnt   = '0;
            ctx_d.full  = 1'b0;
            ctx_d.pull  = 1'b0;
        end else if (stop_ev) begin
            ctx_d.state = ST_IDLE;
            ctx_d.pull  = 1'b0;
            ctx_d.full  = 1'b0;
        end else begin
            unique case (ctx_q.state)
                ST_RX: begin
                    if (scl_rise && !ctx_q.full) begin
                        ctx_d.shreg = {ctx_q.shreg[BYTE_W-2:0], sda_lvl};
                        ctx_d.cnt   = ctx_q.cnt + 1'b1;
                        ctx_d.full  = (ctx_q.cnt == LAST_BIT);
                    end else if (scl_fall && ctx_q.full) begin
                        ctx_d.full = 1'b0;
                        ctx_d.cnt  = '0;
                        unique case (ctx_q.kind)
                            K_ADDR: begin
                                if (ctx_q.shreg[BYTE_W-1:1] == '0) begin
                                    ctx_d.rd_dir = ctx_q.shreg[0];
                                    ctx_d.pull   = 1'b1;
                                    ctx_d.state  = ST_RX_ACK;
                                end else begin
                                    ctx_d.state = ST_SKIP;
                                end
                            end
                            K_INDEX: begin
                                ctx_d.index = ctx_q.shreg;
                                ctx_d.pull  = 1'b1;
                                ctx_d.state = ST_RX_ACK;
                            end
                            default: begin
                                wr_en       = 1'b1;
                                ctx_d.pull  = 1'b1;
                                ctx_d.state = ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        ctx_d.pull = 1'b0;
                        ctx_d.cnt  = '0;
                        unique case (ctx_q.kind)
                            K_ADDR: begin
                                if (ctx_q.rd_dir) begin
                                    ctx_d.state = ST_TX;
                                    ctx_d.shreg = rd_data;
                                    ctx_d.pull  = ~rd_data[BYTE_W-1];
                                end else begin
                                    ctx_d.state = ST_RX;
                                    ctx_d.kind  = K_INDEX;
                                end
                            end
                            K_INDEX: begin
                                ctx_d.state = ST_RX;
                                ctx_d.kind  = K_DATA;
                            end
                            default: begin
                                ctx_d.state = ST_SKIP;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctx_q.cnt == LAST_BIT) begin
                            ctx_d.pull  = 1'b0;
                            ctx_d.state = ST_TX_ACK;
                        end else begin
                            ctx_d.shreg = {ctx_q.shreg[BYTE_W-2:0], 1'b0};
                            ctx_d.pull  = ~ctx_q.shreg[BYTE_W-2];
                            ctx_d.cnt   = ctx_q.cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    ctx_d.pull = 1'b0;
                    if (scl_rise) begin
                        ctx_d.state = ST_SKIP;
                    end
                end
                default: begin
                    ctx_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctx_q <= '{state: ST_IDLE, kind: K_ADDR, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign sda_pull_o = ctx_q.pull;

    // R7
    en_off_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_en_ni |=> (!sda_pull_o && ctx_q.state == ST_IDLE));

    // R10
    drive_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_pull_o) |-> !$past(scl_lvl));

    // R6
    stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_ev && !bus_en_ni) |=> (ctx_q.state == ST_IDLE && !sda_pull_o));

    // R4
    tx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctx_q.state == ST_TX_ACK || ctx_q.state == ST_SKIP) |-> !sda_pull_o);

    // R2
    ack_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sda_pull_o) && ctx_q.state == ST_RX_ACK) |-> $past(ctx_q.full));

endmodule

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;

    localparam int NUM_REGS = 20;
    localparam int HALF     = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic en_n;
    logic scl;
    logic m_sda;
    logic sda_pull;
    logic sda_line;
    logic [NUM_REGS*8-1:0] cfg;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    cfg_serial_slave #(.NUM_REGS(NUM_REGS)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_en_ni  (en_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .cfg_regs_o (cfg)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] model [NUM_REGS];
    logic [7:0] mid_snap;

    function automatic logic [7:0] exp_read(input int idx);
        return (idx < NUM_REGS) ? model[idx] : 8'h00;
    endfunction

    function automatic logic [NUM_REGS*8-1:0] exp_flat();
        logic [NUM_REGS*8-1:0] v;
        for (int k = 0; k < NUM_REGS; k++) v[k*8 +: 8] = model[k];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(HALF);
        scl = 1'b1;   wclk(HALF);
        m_sda = 1'b0; wclk(HALF);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(HALF);
        scl = 1'b1;   wclk(HALF);
        m_sda = 1'b1; wclk(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wclk(HALF);
            scl = 1'b1;   wclk(HALF);
            scl = 1'b0;
        end
    endtask

    task automatic ack_clock(output logic acked);
        m_sda = 1'b1; wclk(HALF);
        scl = 1'b1;   wclk(HALF - 1);
        acked = ~sda_line;
        wclk(1);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input logic ack_bit, output logic [7:0] v);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(HALF);
            scl = 1'b1; wclk(HALF - 1);
            v[i] = sda_line;
            wclk(1);
            scl = 1'b0;
        end
        m_sda = ack_bit; wclk(HALF);
        scl = 1'b1;      wclk(HALF);
        scl = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] data,
                            output logic aa, output logic ai, output logic ad);
        bus_start();
        send_bits(8'h00); ack_clock(aa);
        send_bits(idx);   ack_clock(ai);
        send_bits(data);
        wclk(5);
        mid_snap = (int'(idx) < NUM_REGS) ? cfg[int'(idx)*8 +: 8] : 8'h00;
        ack_clock(ad);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] idx, output logic [7:0] v,
                           output logic aa, output logic ai, output logic ar);
        bus_start();
        send_bits(8'h00); ack_clock(aa);
        send_bits(idx);   ack_clock(ai);
        bus_stop();
        bus_start();
        send_bits(8'h01); ack_clock(ar);
        recv_byte(1'b1, v);
        bus_stop();
    endtask

    initial begin
        logic aa, ai, ad, ar, ax;
        logic [7:0] v;
        int idx;
        logic [7:0] dat;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NUM_REGS; k++) model[k] = 8'h00;
        rst_n = 1'b0; en_n = 1'b0; scl = 1'b1; m_sda = 1'b1;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // R8 reset state
        chk(cfg == '0, "R8 regs after reset", 32'(cfg[31:0]), 0);
        chk(sda_pull == 1'b0, "R8 pull after reset", 32'(sda_pull), 0);
        do_read(8'd0, v, aa, ai, ar);
        chk(v == 8'h00, "R8 read reg0 after reset", 32'(v), 0);

        // R3 R9 directed write, then read back (R4)
        do_write(8'h0F, 8'hF0, aa, ai, ad);
        model[15] = 8'hF0;
        chk(aa && ai && ad, "R2 R3 write acks", {29'd0, aa, ai, ad}, 7);
        chk(mid_snap == 8'hF0, "R9 stored before ack pulse", 32'(mid_snap), 32'hF0);
        chk(cfg == exp_flat(), "R9 flat layout", 32'(cfg[127:96]), 32'(exp_flat() >> 96));
        do_read(8'h0F, v, aa, ai, ar);
        chk(ar, "R4 read address ack", 32'(ar), 1);
        chk(v == 8'hF0, "R1 R4 read data msb first", 32'(v), 32'hF0);

        // R5 out of range
        do_write(8'd200, 8'h5A, aa, ai, ad);
        chk(aa && ai && ad, "R5 out-of-range write acked", {29'd0, aa, ai, ad}, 7);
        chk(cfg == exp_flat(), "R5 out-of-range discarded", 32'(cfg[31:0]), 32'(exp_flat()));
        do_read(8'd200, v, aa, ai, ar);
        chk(v == 8'h00, "R5 out-of-range read zero", 32'(v), 0);

        // R2 address mismatch
        bus_start(); send_bits(8'h02); ack_clock(ax); bus_stop();
        chk(!ax, "R2 address 02 not acked", 32'(ax), 0);
        bus_start(); send_bits(8'h81); ack_clock(ax); bus_stop();
        chk(!ax, "R2 address 81 not acked", 32'(ax), 0);

        // R3 extra byte after data ignored
        bus_start();
        send_bits(8'h00); ack_clock(aa);
        send_bits(8'd3);  ack_clock(ai);
        send_bits(8'h3C); ack_clock(ad);
        send_bits(8'hC3); ack_clock(ax);
        bus_stop();
        model[3] = 8'h3C;
        chk(!ax, "R3 extra byte not acked", 32'(ax), 0);
        chk(cfg[3*8 +: 8] == 8'h3C, "R3 extra byte no write", 32'(cfg[3*8 +: 8]), 32'h3C);

        // R6 repeated start mid-write restarts address phase
        bus_start();
        send_bits(8'h00); ack_clock(aa);
        send_bits(8'd7);  ack_clock(ai);
        bus_start();
        send_bits(8'h00); ack_clock(aa);
        send_bits(8'd8);  ack_clock(ai);
        send_bits(8'h99); ack_clock(ad);
        bus_stop();
        model[8] = 8'h99;
        chk(aa && ad, "R6 restart acked", {30'd0, aa, ad}, 3);
        chk(cfg == exp_flat(), "R6 restart wrote new index only", 32'(cfg[63:32]), 32'(exp_flat() >> 32));

        // R7 disabled bus ignored
        en_n = 1'b1;
        do_write(8'd5, 8'hAA, aa, ai, ad);
        chk(!(aa || ai || ad), "R7 no acks while disabled", {29'd0, aa, ai, ad}, 0);
        chk(cfg == exp_flat(), "R7 no write while disabled", 32'(cfg[63:32]), 32'(exp_flat() >> 32));
        en_n = 1'b0;

        // R7 R10 drop during acknowledge
        bus_start();
        send_bits(8'h00);
        wclk(HALF - 1);
        chk(sda_pull, "R10 ack driven during low phase", 32'(sda_pull), 1);
        en_n = 1'b1;
        wclk(1);
        chk(!sda_pull, "R7 release one clock after disable", 32'(sda_pull), 0);
        scl = 1'b1; wclk(HALF);
        m_sda = 1'b1; wclk(HALF);
        en_n = 1'b0; wclk(HALF);

        // random mix
        for (int n = 0; n < 40; n++) begin
            idx = $urandom_range(0, NUM_REGS + 3);
            dat = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                do_write(8'(idx), dat, aa, ai, ad);
                if (idx < NUM_REGS) model[idx] = dat;
                chk(aa && ai && ad, "R3 random write acks", {29'd0, aa, ai, ad}, 7);
                chk(cfg == exp_flat(), "R5 R9 random write contents", 32'(cfg[31:0]), 32'(exp_flat()));
            end else begin
                do_read(8'(idx), v, aa, ai, ar);
                chk(aa && ai && ar, "R4 random read acks", {29'd0, aa, ai, ar}, 7);
                chk(v == exp_read(idx), "R4 R5 random read data", 32'(v), 32'(exp_read(idx)));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule